// File: doc/BRIEF.md
# Partitioned Gray Up/Down Counter

This block is a 3-bit reflected Gray code counter that steps up or down through eight codes. It is built from two cooperating five-state machines rather than one 3-bit register. The lower machine covers the codes 000, 001, 011 and 010. The upper machine covers 110, 111, 101 and 100. Each machine also has an idle state. Exactly one machine is live at any time, and the output code comes from that machine.

When the live machine has to step into a code that the other machine covers, it does two things in the same clock. It drops to idle, and it raises a single-cycle go request to its peer. The request tells the peer where to enter: at its first code when counting up, or at its last code when counting down. The peer leaves idle on that same clock edge. Because of this, a crossing costs no extra cycle.

Use it wherever a glitch-safe position or pointer code is needed and the split into two smaller controllers is wanted. One reason for the split is that each half can be placed or clock-gated on its own.

Top module: `gray_updown_part`

## Requirements
- R1: On a rising clock edge with `rst_n` low, the output becomes 000. The lower machine is live and the upper machine is idle.
- R2: With `cnt_en`=1 and `cnt_up`=1, every rising edge moves the output one place forward in the order 000, 001, 011, 010, 110, 111, 101, 100.
- R3: With `cnt_en`=1 and `cnt_up`=0, every rising edge moves the output one place backward in that same order.
- R4: The count wraps at both ends. Counting up from 100 gives 000, and counting down from 000 gives 100. Each wrap is an ordinary single-cycle step.
- R5: Every enabled step changes exactly one output bit.
- R6: With `cnt_en`=0 the output holds its value, both machines keep their state, and no go request is raised.
- R7: Exactly one of the two machines is out of idle at all times after reset, and the output is the code of that machine.
- R8: Crossing between 010 and 110 takes one clock in either direction, with no repeated or skipped code. The go request makes the peer enter at its first code when counting up and at its last code when counting down.
- R9: The direction may change on any enabled clock, including the clock right after a crossing. The next step then follows the new direction.
- R10: Asserting reset in the middle of a count returns the output to 000 on the next edge, whatever the code was.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cnt_en | input | 1 | Count enable; 1 = step on this edge |
| cnt_up | input | 1 | Direction; 1 = up, 0 = down |
| gray_o | output | 3 | Current Gray code of the live machine |

## Verification
A fault in the position register of the live machine shows on `gray_o` at the next edge. The wrong code appears at once, and the step after it usually changes more than one bit. A fault in the handoff shows within one enabled clock of a crossing. A lost request leaves both machines idle and the output stuck. A duplicated request, or one that names the wrong entry point, makes the output repeat, skip or jump across the code order. The bench drives every crossing and wrap in both directions and reverses direction right at the boundaries, so these faults come out within a few cycles of the event.

// File: rtl/gray_part_pkg.sv
// Package: shared types for the partitioned Gray counter.
// Assumes: one go request travels in each direction between the two halves.
package gray_part_pkg;

    // Request from the machine that is leaving to its idle peer.
    typedef struct packed {
        logic go;      // one-cycle request to leave idle
        logic to_top;  // 1 = enter at the last code of the half, 0 = at the first
    } handoff_t;

endpackage

// File: rtl/gray_encode.sv
// Module: gray_encode
// Turns a sequence index into its reflected Gray code.
// Assumes: the index is plain binary, with the width given by W.
module gray_encode #(
    parameter int W = 3
) (
    input  logic [W-1:0] idx_i,
    output logic [W-1:0] code_o
);

    // Reflected code: each bit is the XOR of an index bit and the bit above it.
    always_comb begin
        code_o = idx_i ^ (idx_i >> 1);
    end

endmodule

// File: rtl/gray_half_fsm.sv
// Module: gray_half_fsm
// One half of the partitioned counter. It holds 2**(W-1) counting positions
// plus an idle state. At its own edge of the sequence it goes idle and raises
// a go request so that the peer takes over on the same clock edge.
// Assumes: the peer is idle whenever this half is live, and it is never
// sent a request while it is live itself.
module gray_half_fsm
    import gray_part_pkg::*;
#(
    parameter int W            = 3,
    parameter bit UPPER        = 1'b0,
    parameter bit START_ACTIVE = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          up,
    input  handoff_t      go_in,
    output handoff_t      go_out,
    output logic          idle_o,
    output logic [W-1:0]  idx_o
);

    localparam int           PW  = W - 1;
    localparam logic [PW-1:0] TOP = '1;
    localparam logic [PW-1:0] BOT = '0;

    logic          idle_q;
    logic [PW-1:0] pos_q;
    logic          at_edge;

    // True when the next step in the current direction leaves this half.
    always_comb begin
        at_edge = up ? (pos_q == TOP) : (pos_q == BOT);
    end

    // Raise the request to the peer in the same cycle that this half leaves.
    always_comb begin
        go_out.go     = !idle_q && en && at_edge;
        go_out.to_top = !up;
    end

    // State update: reset, wake from idle, step, or leave for the peer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_q <= !START_ACTIVE;
            pos_q  <= BOT;
        end else if (idle_q) begin
            if (go_in.go) begin
                idle_q <= 1'b0;
                pos_q  <= go_in.to_top ? TOP : BOT;
            end
        end else if (en) begin
            if (at_edge) begin
                idle_q <= 1'b1;
            end else if (up) begin
                pos_q <= pos_q + 1'b1;
            end else begin
                pos_q <= pos_q - 1'b1;
            end
        end
    end

    // Index in the whole sequence: the top bit says which half this is.
    always_comb begin
        idle_o = idle_q;
        idx_o  = {UPPER, pos_q};
    end

endmodule

// File: rtl/gray_out_select.sv
// Module: gray_out_select
// Passes on the code of whichever half is live.
// Assumes: exactly one half is out of idle.
module gray_out_select #(
    parameter int W = 3
) (
    input  logic [1:0]        idle_i,
    input  logic [1:0][W-1:0] code_i,
    output logic [W-1:0]      code_o
);

    // The lower half drives the output unless it is idle.
    always_comb begin
        code_o = idle_i[0] ? code_i[1] : code_i[0];
    end

endmodule

// File: rtl/gray_updown_part.sv
// Module: gray_updown_part (top)
// Gray up/down counter built from two communicating half machines. Half 0
// covers the first half of the sequence and half 1 the second. Control moves
// between them through one-cycle go requests, with no idle cycle.
// Assumes: a synchronous active-low reset is applied before the first use.
module gray_updown_part
    import gray_part_pkg::*;
#(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnt_en,
    input  logic         cnt_up,
    output logic [W-1:0] gray_o
);

    handoff_t          hand [2];
    logic [1:0]        idle_v;
    logic [1:0][W-1:0] idx_v;
    logic [1:0][W-1:0] code_v;

    // Handy names for the checker.
    logic     a_idle;
    logic     b_idle;
    handoff_t a_to_b;
    handoff_t b_to_a;

    genvar g;
    generate
        for (g = 0; g < 2; g++) begin : g_half
            gray_half_fsm #(
                .W            (W),
                .UPPER        (g == 1),
                .START_ACTIVE (g == 0)
            ) u_half (
                .clk    (clk),
                .rst_n  (rst_n),
                .en     (cnt_en),
                .up     (cnt_up),
                .go_in  (hand[1-g]),
                .go_out (hand[g]),
                .idle_o (idle_v[g]),
                .idx_o  (idx_v[g])
            );

            gray_encode #(.W(W)) u_enc (
                .idx_i  (idx_v[g]),
                .code_o (code_v[g])
            );
        end
    endgenerate

    gray_out_select #(.W(W)) u_sel (
        .idle_i (idle_v),
        .code_i (code_v),
        .code_o (gray_o)
    );

    // Give the internal handshakes readable names.
    always_comb begin
        a_idle = idle_v[0];
        b_idle = idle_v[1];
        a_to_b = hand[0];
        b_to_a = hand[1];
    end

endmodule

// File: rtl/gray_updown_part_chk.sv
// Module: gray_updown_part_chk
// Checks the counter over time: how it steps and holds, and how the two
// halves hand off to each other.
// Assumes: it is bound to gray_updown_part, with the internal idle flags and
// requests connected.
module gray_updown_part_chk
    import gray_part_pkg::*;
#(
    parameter int W = 3
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cnt_en,
    input logic         cnt_up,
    input logic [W-1:0] gray_o,
    input logic         a_idle,
    input logic         b_idle,
    input handoff_t     a_to_b,
    input handoff_t     b_to_a
);

    localparam int HALF = 1 << (W - 1);
    localparam int LAST = 2 * HALF - 1;
    localparam logic [W-1:0] A_LOW  = '0;
    localparam logic [W-1:0] A_HIGH = W'((HALF - 1) ^ ((HALF - 1) >> 1));
    localparam logic [W-1:0] B_LOW  = W'(HALF ^ (HALF >> 1));
    localparam logic [W-1:0] B_HIGH = W'(LAST ^ (LAST >> 1));

    assert_one_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_en |=> $countones(gray_o ^ $past(gray_o)) == 1);

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en |=> $stable(gray_o));

    assert_no_go_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (a_to_b.go || b_to_a.go) |-> cnt_en);

    assert_one_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
        a_idle != b_idle);

    assert_enter_b_up_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (a_to_b.go && cnt_up) |=> (gray_o == B_LOW && !b_idle));

    assert_enter_b_dn_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (a_to_b.go && !cnt_up) |=> (gray_o == B_HIGH && !b_idle));

    assert_enter_a_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (b_to_a.go && cnt_up) |=> (gray_o == A_LOW && !a_idle));

    assert_enter_a_dn_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (b_to_a.go && !cnt_up) |=> (gray_o == A_HIGH && !a_idle));

endmodule

bind gray_updown_part gray_updown_part_chk #(.W(W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cnt_en (cnt_en),
    .cnt_up (cnt_up),
    .gray_o (gray_o),
    .a_idle (a_idle),
    .b_idle (b_idle),
    .a_to_b (a_to_b),
    .b_to_a (b_to_a)
);

// File: tb/gray_updown_part_test.sv
// Scoreboard bench: the driver works out the expected code for every clock
// and queues it, and the monitor compares each queued value after the edge.
module gray_updown_part_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnt_en = 1'b0;
    logic       cnt_up = 1'b1;
    logic [2:0] gray_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [2:0] exp_q [$];
    string      tag_q [$];
    bit         stp_q [$];

    // Expected code at each position of the sequence, taken from R2.
    logic [2:0] seq_tab [8] = '{3'b000, 3'b001, 3'b011, 3'b010,
                                3'b110, 3'b111, 3'b101, 3'b100};
    int  mdl_idx  = 0;
    bit  prev_dir = 1'b1;
    bit  seen_rst = 1'b0;

    gray_updown_part uut (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt_en (cnt_en),
        .cnt_up (cnt_up),
        .gray_o (gray_o)
    );

    always #5 clk = ~clk;

    // Driver: put the inputs on at a falling edge and queue the result
    // expected after the next rising edge.
    task automatic drive(input bit r, input bit e, input bit u);
        string t;
        @(negedge clk);
        rst_n  = r;
        cnt_en = e;
        cnt_up = u;
        if (!r) begin
            t = seen_rst ? "R10" : "R1";
            seen_rst = 1'b1;
            mdl_idx = 0;
        end else if (!e) begin
            t = "R6";
        end else begin
            if (u != prev_dir)                      t = "R9";
            else if (u && mdl_idx == 7)             t = "R4";
            else if (!u && mdl_idx == 0)            t = "R4";
            else if (u && mdl_idx == 3)             t = "R8 R7";
            else if (!u && mdl_idx == 4)            t = "R8 R7";
            else                                    t = u ? "R2" : "R3";
            prev_dir = u;
            mdl_idx = u ? (mdl_idx + 1) % 8 : (mdl_idx + 7) % 8;
        end
        exp_q.push_back(seq_tab[mdl_idx]);
        tag_q.push_back(t);
        stp_q.push_back(r && e);
    endtask

    // Monitor: compare each queued value 2 ns after the rising edge.
    logic [2:0] prev_out;
    bit         prev_ok = 1'b0;
    always @(posedge clk) begin
        logic [2:0] e;
        string      t;
        bit         s;
        #2;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            s = stp_q.pop_front();
            checks++;
            if (gray_o !== e) begin
                errors++;
                $display("FAIL %s: gray_o=%b expected=%b", t, gray_o, e);
            end
            if (s && prev_ok) begin
                checks++;
                if ($countones(gray_o ^ prev_out) != 1) begin
                    errors++;
                    $display("FAIL R5: step %b -> %b changes %0d bits, expected 1",
                             prev_out, gray_o, $countones(gray_o ^ prev_out));
                end
            end
            prev_out = gray_o;
            prev_ok  = 1'b1;
        end
    end

    // Stimulus: directed cases first, then a pseudo-random walk.
    initial begin
        logic [7:0] lfsr = 8'hA5;
        drive(0, 0, 1);
        drive(0, 1, 1);
        for (int i = 0; i < 18; i++) drive(1, 1, 1);   // two full laps up
        for (int i = 0; i < 4; i++)  drive(1, 0, i[0]); // hold, both directions
        for (int i = 0; i < 18; i++) drive(1, 1, 0);   // laps down
        // to 010, then reverse at each boundary
        while (mdl_idx != 3) drive(1, 1, 1);
        drive(1, 1, 1);                                 // cross up into 110
        drive(1, 1, 0);                                 // straight back to 010
        drive(1, 1, 1);
        drive(1, 0, 0);                                 // hold while in upper half
        drive(1, 1, 0);
        while (mdl_idx != 0) drive(1, 1, 0);
        drive(1, 1, 0);                                 // wrap down to 100
        drive(1, 1, 1);                                 // wrap back up to 000
        drive(1, 1, 1);
        drive(1, 1, 1);
        drive(1, 1, 1);
        drive(1, 1, 1);                                 // in upper half now
        drive(0, 1, 1);                                 // reset mid-count
        for (int i = 0; i < 200; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            drive(!(lfsr[7:3] == 5'd0), lfsr[0] | lfsr[2], lfsr[1]);
        end
        drive(1, 0, 1);
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule